// File: doc/BRIEF.md
# USB Device Interrupt Register Bank

This block is the software-visible register bank of a full-speed USB device controller. A 16-bit register bus reaches four registers: a control register that carries one interrupt enable per event together with the power and reset command bits, an interrupt status register, a device address register and a buffer table base register. The block drives the command bits, the device address and the buffer base out to the protocol engine, transceiver, suspend logic and packet memory. It does not implement any of those units.

Hardware raises single-cycle event pulses. Each pulse sets a sticky status flag. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag as it is, so one flag can be cleared on its own by writing the inverse of its bit. The transfer engine loads the endpoint number and direction of the last completed transaction into read-only status fields. One level interrupt output is asserted while any flag is set whose enable is also set.

The bus is a single-cycle strobe. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr`. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `usbdev_irq_regbank`

## Requirements
- R1: After reset the control register reads 0x0003, and the status, device address and buffer base registers read 0x0000. `irq` is low, `cmd_force_reset` and `cmd_power_down` are high, and the other commands are low.
- R2: A pulse on `evt_pulse[i]` sets status bit 8+i. The status bits, from bit 15 down to bit 8, are: correct transfer, DMA over/underrun, error, wakeup, suspend, bus reset, start of frame, expected start of frame. The flag stays set until software clears it.
- R3: A write to the status register (word offset 1) clears each flag whose data bit in 15:8 is 0 and leaves unchanged each flag whose data bit is 1.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Status bit 4 (direction, 1 = device to host) and bits 3:0 (endpoint number) are loaded from `xfer_dir` and `xfer_ep` when `xfer_done` is high. Status writes never change them, and status bits 7:5 read 0.
- R6: Control bits 15:8 are interrupt enables, at the same bit positions as the status flags. `irq` is high exactly while some flag and its enable are both 1.
- R7: Control bits 4:0 are read/write and drive the commands: bit 4 `cmd_resume`, bit 3 `cmd_force_susp`, bit 2 `cmd_low_power`, bit 1 `cmd_power_down`, bit 0 `cmd_force_reset`. Control bits 7:5 read 0.
- R8: The device address register (word offset 2) stores the address in bits 6:0 and the enable in bit 7. These drive `dev_addr` and `dev_addr_en`, and bits 15:8 read 0.
- R9: The buffer base register (word offset 3) stores the written value with bits 2:0 forced to 0, and drives `buf_base`.
- R10: The control register is at word offset 0. Offsets 4 to 7 are unmapped: writes to them change no register, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| evt_pulse | input | 8 | Event pulses; bit i sets status flag 8+i |
| xfer_done | input | 1 | Loads the endpoint and direction fields |
| xfer_dir | input | 1 | Direction of the completed transaction |
| xfer_ep | input | 4 | Endpoint number of the completed transaction |
| irq | output | 1 | Masked interrupt request |
| cmd_resume | output | 1 | Resume request command |
| cmd_force_susp | output | 1 | Force suspend command |
| cmd_low_power | output | 1 | Low-power mode command |
| cmd_power_down | output | 1 | Power down command |
| cmd_force_reset | output | 1 | Force USB reset command |
| dev_addr | output | 7 | Device address |
| dev_addr_en | output | 1 | Device address enable |
| buf_base | output | 16 | Buffer table base, 8-byte aligned |

## Verification
Each event input is pulsed alone, and the read-back must show exactly the matching flag. This separates a correct bit mapping from a shifted or reversed one. Clearing is tried with one zero in a field of ones, with all ones and with all zeros. This separates write-zero-to-clear from write-one-to-clear and from plain overwrite. A clear and an event on the same flag in the same cycle checks the priority. The interrupt is tried with a set flag that is not enabled and with one that is, which separates masking from a plain OR of the flags. Writes of all ones to the other registers and to unmapped offsets show that reserved bits, the alignment bits and the unused offsets hold nothing.

// File: rtl/usbdev_rb_pkg.sv
package usbdev_rb_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_EVT  = 8;
  localparam int EP_W     = 4;
  localparam int DADDR_W  = 7;
  localparam int EVT_LSB  = 8;
  localparam int DIR_BIT  = 4;
  localparam int CMD_W    = 5;

  typedef enum logic [1:0] {
    RSEL_CTRL  = 2'd0,
    RSEL_STAT  = 2'd1,
    RSEL_DADDR = 2'd2,
    RSEL_BASE  = 2'd3
  } rsel_e;

  typedef struct packed {
    logic resume;
    logic force_susp;
    logic low_power;
    logic power_down;
    logic force_reset;
  } cmd_t;

  localparam cmd_t CMD_RST_VAL = '{resume: 1'b0, force_susp: 1'b0,
                                   low_power: 1'b0, power_down: 1'b1,
                                   force_reset: 1'b1};
endpackage

// File: rtl/usbdev_rst_sync.sv
module usbdev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/usbdev_ctrl_reg.sv
module usbdev_ctrl_reg
  import usbdev_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_EVT-1:0] evt_mask,
  output cmd_t               cmd
);
  logic [NUM_EVT-1:0] mask_q, mask_d;
  cmd_t               cmd_q, cmd_d;

  always_comb begin
    mask_d = mask_q;
    cmd_d  = cmd_q;
    if (wr_en) begin
      mask_d = wdata[EVT_LSB +: NUM_EVT];
      cmd_d  = cmd_t'(wdata[CMD_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cmd_q  <= CMD_RST_VAL;
    end else begin
      mask_q <= mask_d;
      cmd_q  <= cmd_d;
    end
  end

  assign evt_mask = mask_q;
  assign cmd      = cmd_q;
endmodule

// File: rtl/usbdev_evt_status.sv
module usbdev_evt_status
  import usbdev_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_EVT-1:0] wr_keep,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               xfer_done,
  input  logic               xfer_dir,
  input  logic [EP_W-1:0]    xfer_ep,
  output logic [NUM_EVT-1:0] flags,
  output logic               last_dir,
  output logic [EP_W-1:0]    last_ep
);
  logic [NUM_EVT-1:0] flag_q, flag_d;
  logic               dir_q, dir_d;
  logic [EP_W-1:0]    ep_q, ep_d;

  // one sticky flag per event; a pulse outranks a clear in the same cycle
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic clr;
    assign clr       = wr_en & ~wr_keep[i];
    assign flag_d[i] = evt_pulse[i] | (flag_q[i] & ~clr);
  end

  always_comb begin
    dir_d = dir_q;
    ep_d  = ep_q;
    if (xfer_done) begin
      dir_d = xfer_dir;
      ep_d  = xfer_ep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      dir_q  <= 1'b0;
      ep_q   <= '0;
    end else begin
      flag_q <= flag_d;
      dir_q  <= dir_d;
      ep_q   <= ep_d;
    end
  end

  assign flags    = flag_q;
  assign last_dir = dir_q;
  assign last_ep  = ep_q;
endmodule

// File: rtl/usbdev_addr_regs.sv
module usbdev_addr_regs
  import usbdev_rb_pkg::*;
#(
  parameter int ALIGN_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               daddr_wr,
  input  logic               base_wr,
  input  logic [REG_W-1:0]   wdata,
  output logic [DADDR_W-1:0] dev_addr,
  output logic               dev_addr_en,
  output logic [REG_W-1:0]   buf_base
);
  localparam int BASE_HI_W = REG_W - ALIGN_BITS;

  logic [DADDR_W-1:0]   addr_q, addr_d;
  logic                 en_q, en_d;
  logic [BASE_HI_W-1:0] base_q, base_d;

  always_comb begin
    addr_d = addr_q;
    en_d   = en_q;
    base_d = base_q;
    if (daddr_wr) begin
      addr_d = wdata[DADDR_W-1:0];
      en_d   = wdata[DADDR_W];
    end
    if (base_wr) base_d = wdata[REG_W-1:ALIGN_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      base_q <= '0;
    end else begin
      addr_q <= addr_d;
      en_q   <= en_d;
      base_q <= base_d;
    end
  end

  assign dev_addr    = addr_q;
  assign dev_addr_en = en_q;
  assign buf_base    = {base_q, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/usbdev_irq_regbank.sv
module usbdev_irq_regbank
  import usbdev_rb_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ALIGN_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               xfer_done,
  input  logic               xfer_dir,
  input  logic [EP_W-1:0]    xfer_ep,
  output logic               irq,
  output logic               cmd_resume,
  output logic               cmd_force_susp,
  output logic               cmd_low_power,
  output logic               cmd_power_down,
  output logic               cmd_force_reset,
  output logic [DADDR_W-1:0] dev_addr,
  output logic               dev_addr_en,
  output logic [REG_W-1:0]   buf_base
);
  localparam int SEL_W = 2;

  logic               rst_sync_n;
  logic               in_map;
  rsel_e              rsel;
  logic               wr_ctrl, wr_stat, wr_daddr, wr_base;
  logic [NUM_EVT-1:0] evt_mask;
  logic [NUM_EVT-1:0] evt_flags;
  cmd_t               cmd;
  logic               last_dir;
  logic [EP_W-1:0]    last_ep;

  usbdev_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode: upper offset bits must be zero to hit a register
  if (ADDR_W > SEL_W) begin : g_hi_dec
    assign in_map = (bus_addr[ADDR_W-1:SEL_W] == '0);
  end else begin : g_no_hi
    assign in_map = 1'b1;
  end
  assign rsel = rsel_e'(bus_addr[SEL_W-1:0]);

  always_comb begin
    wr_ctrl  = 1'b0;
    wr_stat  = 1'b0;
    wr_daddr = 1'b0;
    wr_base  = 1'b0;
    if (bus_sel && bus_we && in_map) begin
      unique case (rsel)
        RSEL_CTRL:  wr_ctrl  = 1'b1;
        RSEL_STAT:  wr_stat  = 1'b1;
        RSEL_DADDR: wr_daddr = 1'b1;
        RSEL_BASE:  wr_base  = 1'b1;
      endcase
    end
  end

  usbdev_ctrl_reg ctrl_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_ctrl),
    .wdata    (bus_wdata),
    .evt_mask (evt_mask),
    .cmd      (cmd)
  );

  usbdev_evt_status stat_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_stat),
    .wr_keep   (bus_wdata[EVT_LSB +: NUM_EVT]),
    .evt_pulse (evt_pulse),
    .xfer_done (xfer_done),
    .xfer_dir  (xfer_dir),
    .xfer_ep   (xfer_ep),
    .flags     (evt_flags),
    .last_dir  (last_dir),
    .last_ep   (last_ep)
  );

  usbdev_addr_regs #(.ALIGN_BITS(ALIGN_BITS)) addr_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .daddr_wr    (wr_daddr),
    .base_wr     (wr_base),
    .wdata       (bus_wdata),
    .dev_addr    (dev_addr),
    .dev_addr_en (dev_addr_en),
    .buf_base    (buf_base)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      unique case (rsel)
        RSEL_CTRL: begin
          bus_rdata[EVT_LSB +: NUM_EVT] = evt_mask;
          bus_rdata[CMD_W-1:0]          = cmd;
        end
        RSEL_STAT: begin
          bus_rdata[EVT_LSB +: NUM_EVT] = evt_flags;
          bus_rdata[DIR_BIT]            = last_dir;
          bus_rdata[EP_W-1:0]           = last_ep;
        end
        RSEL_DADDR: begin
          bus_rdata[DADDR_W-1:0] = dev_addr;
          bus_rdata[DADDR_W]     = dev_addr_en;
        end
        RSEL_BASE: bus_rdata = buf_base;
      endcase
    end
  end

  assign irq             = |(evt_flags & evt_mask);
  assign cmd_resume      = cmd.resume;
  assign cmd_force_susp  = cmd.force_susp;
  assign cmd_low_power   = cmd.low_power;
  assign cmd_power_down  = cmd.power_down;
  assign cmd_force_reset = cmd.force_reset;
endmodule

// File: rtl/usbdev_irq_regbank_chk.sv
module usbdev_irq_regbank_chk
  import usbdev_rb_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ALIGN_BITS = 3
) (
  input logic               clk,
  input logic               rst_n_int,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [REG_W-1:0]   bus_wdata,
  input logic [REG_W-1:0]   bus_rdata,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               xfer_done,
  input logic [NUM_EVT-1:0] flags,
  input logic [EP_W-1:0]    ep_id,
  input logic               dir,
  input logic               irq,
  input logic [REG_W-1:0]   buf_base
);
  localparam logic [REG_W-1:0] ALIGN_MASK = REG_W'((1 << ALIGN_BITS) - 1);
  localparam logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FIRST_GAP = ADDR_W'(4);

  logic stat_wr;
  assign stat_wr = bus_sel && bus_we && (bus_addr == STAT_OFS);

  // R2 / R4: a pulse always leaves its flag set on the next cycle
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n_int)
    (evt_pulse != '0) |=> ((flags & $past(evt_pulse)) == $past(evt_pulse)));

  // R3: write-zero clears, write-one keeps
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n_int)
    (stat_wr && evt_pulse == '0) |=>
      (flags == ($past(flags) & $past(bus_wdata[EVT_LSB +: NUM_EVT]))));

  // R5: id fields move only on a completed transfer
  a_r5_id_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    !xfer_done |=> ($stable(ep_id) && $stable(dir)));

  // R6: no interrupt without a pending flag
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> (flags != '0));

  // R9: base stays aligned
  a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n_int)
    (buf_base & ALIGN_MASK) == '0);

  // R10: unmapped reads return zero
  a_r10_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_sel && !bus_we && bus_addr >= FIRST_GAP) |-> (bus_rdata == '0));
endmodule

bind usbdev_irq_regbank usbdev_irq_regbank_chk #(
  .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
) chk_i (
  .clk       (clk),
  .rst_n_int (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_pulse (evt_pulse),
  .xfer_done (xfer_done),
  .flags     (evt_flags),
  .ep_id     (last_ep),
  .dir       (last_dir),
  .irq       (irq),
  .buf_base  (buf_base)
);

// File: tb/usbdev_irq_regbank_tb_top.sv
module usbdev_irq_regbank_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        xfer_done = 1'b0;
  logic        xfer_dir = 1'b0;
  logic [3:0]  xfer_ep = '0;
  logic        irq, cmd_resume, cmd_force_susp, cmd_low_power;
  logic        cmd_power_down, cmd_force_reset, dev_addr_en;
  logic [6:0]  dev_addr;
  logic [15:0] buf_base;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbdev_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .xfer_done(xfer_done), .xfer_dir(xfer_dir),
    .xfer_ep(xfer_ep), .irq(irq), .cmd_resume(cmd_resume),
    .cmd_force_susp(cmd_force_susp), .cmd_low_power(cmd_low_power),
    .cmd_power_down(cmd_power_down), .cmd_force_reset(cmd_force_reset),
    .dev_addr(dev_addr), .dev_addr_en(dev_addr_en), .buf_base(buf_base)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic xfer(logic d, logic [3:0] ep);
    @(negedge clk);
    xfer_done = 1'b1; xfer_dir = d; xfer_ep = ep;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); check("R1 ctrl reset", v, 16'h0003);
    rd(3'd1, v); check("R1 status reset", v, 16'h0000);
    rd(3'd2, v); check("R1 daddr reset", v, 16'h0000);
    rd(3'd3, v); check("R1 base reset", v, 16'h0000);
    check("R1 irq reset", {15'd0, irq}, 16'h0);
    check("R1 cmds reset", {11'd0, cmd_resume, cmd_force_susp, cmd_low_power,
                            cmd_power_down, cmd_force_reset}, 16'h0003);
  endtask

  task automatic t_each_event();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      rd(3'd1, v); check("R2 single event", v, 16'(1 << (8 + i)));
      check("R6 unmasked no irq", {15'd0, irq}, 16'h0);
      wr(3'd1, ~16'(1 << (8 + i)));
      rd(3'd1, v); check("R3 clear single", v, 16'h0000);
    end
  endtask

  task automatic t_clear_rules();
    logic [15:0] v;
    pulse(8'hFF);
    rd(3'd1, v); check("R2 all events", v, 16'hFF00);
    wr(3'd1, 16'hFEFF);
    rd(3'd1, v); check("R3 clear bit8 only", v, 16'hFE00);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, v); check("R3 ones keep", v, 16'hFE00);
    wr(3'd1, 16'h7FFF);
    rd(3'd1, v); check("R3 clear bit15 only", v, 16'h7E00);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R3 clear all", v, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    pulse(8'h03);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0000;
    evt_pulse = 8'h81;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; evt_pulse = '0;
    rd(3'd1, v); check("R4 event beats clear", v, 16'h8100);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    xfer(1'b1, 4'hA);
    rd(3'd1, v); check("R5 id load", v, 16'h001A);
    wr(3'd1, 16'hFFE0);
    rd(3'd1, v); check("R5 id read-only", v, 16'h001A);
    xfer(1'b0, 4'h3);
    rd(3'd1, v); check("R5 id reload", v, 16'h0003);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(3'd0, 16'h0400);
    check("R6 no flag no irq", {15'd0, irq}, 16'h0);
    pulse(8'h02);
    check("R6 masked-off flag", {15'd0, irq}, 16'h0);
    pulse(8'h04);
    check("R6 enabled flag irq", {15'd0, irq}, 16'h1);
    wr(3'd1, 16'hFBFF);
    check("R6 irq drops on clear", {15'd0, irq}, 16'h0);
    rd(3'd1, v); check("R3 other flag kept", v, 16'h0203);
    wr(3'd0, 16'hFF00);
    check("R6 enable pending flag", {15'd0, irq}, 16'h1);
    wr(3'd1, 16'h0000);
    check("R6 irq after clear all", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_ctrl();
    logic [15:0] v;
    wr(3'd0, 16'h00FF);
    rd(3'd0, v); check("R7 ctrl low bits", v, 16'h001F);
    check("R7 cmds all on", {11'd0, cmd_resume, cmd_force_susp, cmd_low_power,
                             cmd_power_down, cmd_force_reset}, 16'h001F);
    wr(3'd0, 16'h0010);
    check("R7 resume only", {11'd0, cmd_resume, cmd_force_susp, cmd_low_power,
                             cmd_power_down, cmd_force_reset}, 16'h0010);
  endtask

  task automatic t_addr();
    logic [15:0] v;
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); check("R8 daddr ones", v, 16'h00FF);
    check("R8 daddr outputs", {8'd0, dev_addr_en, dev_addr}, 16'h00FF);
    wr(3'd2, 16'h0025);
    check("R8 daddr disabled", {8'd0, dev_addr_en, dev_addr}, 16'h0025);
  endtask

  task automatic t_base();
    logic [15:0] v;
    wr(3'd3, 16'h1237);
    rd(3'd3, v); check("R9 base aligned", v, 16'h1230);
    check("R9 base output", buf_base, 16'h1230);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v); check("R9 base ones", v, 16'hFFF8);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    for (int a = 4; a < 8; a++) wr(3'(a), 16'hFFFF);
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v); check("R10 gap reads zero", v, 16'h0000);
    end
    rd(3'd0, v); check("R10 ctrl untouched", v, 16'h0010);
    rd(3'd1, v); check("R10 status untouched", v, 16'h0003);
    rd(3'd2, v); check("R10 daddr untouched", v, 16'h0025);
    rd(3'd3, v); check("R10 base untouched", v, 16'hFFF8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_each_event();
    t_clear_rules();
    t_collision();
    t_ident();
    t_irq();
    t_ctrl();
    t_addr();
    t_base();
    t_unmapped();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule